// File: doc/BRIEF.md
# Nibble-Selector Interrupt Entry and Return Sequencer

This block is the interrupt-entry and return path of a small 8-bit processor core. It holds sixteen 16-bit address registers and two 4-bit selectors: `p` chooses which register acts as the program counter and `x` chooses which one acts as the data pointer. The block runs a reduced instruction subset through a byte-wide memory port. The subset is: select data pointer, return, return-and-disable, save the temporary byte, and output to one of seven ports. Between instructions it can run a one-cycle interrupt response. That response parks both selectors in a packed temporary byte `t` and switches to a fixed handler register pair.

The memory port makes one access per cycle. The address and the strobes come from registers and selectors inside the block. Read data must be valid on `mem_rdata` within the same cycle as the address, and a write happens at the clock edge that ends a cycle with `mem_wr` high. Output bytes leave on a valid/ready stream. When `out_valid` is high and `out_ready` is low, the output instruction stalls in its execute cycle. During a stall the port number, data and address are held, and the data pointer does not advance. The transfer completes in the cycle where both are high. Control pins (`irq`) and the visible state pins are plain levels. Opcodes outside the subset execute as one fetch plus one idle execute cycle.

Top module: `nib_irq_ctrl`

## Requirements
- R1: After reset `x`, `p`, `t` and `ie` read 0 and the first cycle is a fetch from address 0 (`mem_rd`=1, `mem_addr`=0). `out_valid` is 0.
- R2: An interrupt response ends with `t` = {old x, old p} (x in bits 7:4, p in bits 3:0), `x`=2, `p`=1 and `ie`=0. The next fetch comes from register 1.
- R3: While `ie` is 0 the level on `irq` has no effect: instructions keep fetching from consecutive addresses and no response cycle occurs.
- R4: Opcode 0x70 reads the byte at R(x), loads its bits 7:4 into `x` and bits 3:0 into `p`, increments R(x) by one and sets `ie` to 1.
- R5: Opcode 0x71 does the same as 0x70 but clears `ie` to 0.
- R6: Every fetch increments R(p). When x equals p, 0x70, 0x71 and the output opcodes read the byte right after the opcode and step the same register past it.
- R7: Opcodes 0x61 to 0x67 present the byte at R(x) on `out_data`, with `out_port` equal to bits 2:0 of the opcode, and increment R(x) once the transfer completes.
- R8: Opcode 0xEn loads n into `x`.
- R9: Opcode 0x78 writes `t` to memory at R(x) (`mem_wr`=1, `mem_wdata`=`t`) without changing R(x).
- R10: The first instruction after an interrupt response ignores `irq`, even when it sets `ie` to 1.
- R11: If `irq` is still high when an instruction leaves `ie` at 1, a new response cycle follows before any further fetch.
- R12: While `out_valid` is high and `out_ready` low, `out_valid`, `out_port`, `out_data` and `mem_addr` stay unchanged, and no fetch starts.
- R13: Every instruction takes one fetch cycle and one execute cycle (plus stall cycles). The response takes one cycle with `mem_rd` and `mem_wr` both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe for this cycle |
| mem_wr | output | 1 | Write strobe, write at the closing edge |
| mem_wdata | output | 8 | Write data (the `t` byte) |
| mem_rdata | input | 8 | Read data, valid within the cycle |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Receiver accepts the output byte |
| out_port | output | 3 | Output port number 1..7 |
| out_data | output | 8 | Output byte |
| x | output | 4 | Data-pointer selector |
| p | output | 4 | Program-counter selector |
| t | output | 8 | Temporary byte {x, p} saved at interrupt entry |
| ie | output | 1 | Interrupt enable |

## Verification
Most register or selector faults show up at the ports within one instruction. A wrong register increment shows on `mem_addr` at the next fetch or operand read. A wrong selector shows on `x` and `p` at the next fetch, and it also moves the following addresses. An error in the enable flag or the first-instruction guard shows only when `irq` is high. It then appears as a response cycle with both strobes low, in the cycle after the execute cycle, or as the absence of one. A wrong temporary byte stays hidden until a save instruction puts it on `mem_wdata`, or until `t` is read directly.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int SELW = 4;
  localparam int NREG = 1 << SELW;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_INTR  = 2'd2
  } seq_t;

  typedef struct packed {
    logic            sel_x;
    logic            ret;
    logic            dis;
    logic            sav;
    logic            outp;
    logic [SELW-1:0] arg;
  } dec_t;
endpackage

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel,
  input  logic            inc_en,
  output logic [AW-1:0]   val
);
  logic [NREG-1:0][AW-1:0] regs_q;
  logic [NREG-1:0]         hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = inc_en && (sel == SELW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)      regs_q[i] <= '0;
      else if (hit[i]) regs_q[i] <= regs_q[i] + AW'(1);
    end
  end

  assign val = regs_q[sel];
endmodule

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic [7:0] op,
  output dec_t       d
);
  always_comb begin
    d       = '0;
    d.arg   = op[3:0];
    d.sel_x = (op[7:4] == 4'hE);
    d.ret   = (op == 8'h70);
    d.dis   = (op == 8'h71);
    d.sav   = (op == 8'h78);
    d.outp  = (op[7:4] == 4'h6) && !op[3] && (op[2:0] != 3'd0);
  end
endmodule

// File: rtl/nib_irq_ctrl.sv
module nib_irq_ctrl
  import nib_pkg::*;
#(
  parameter int              AW    = 16,
  parameter logic [SELW-1:0] INT_P = 4'd1,
  parameter logic [SELW-1:0] INT_X = 4'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_port,
  output logic [7:0]    out_data,
  output logic [3:0]    x,
  output logic [3:0]    p,
  output logic [7:0]    t,
  output logic          ie
);
  seq_t            state_q;
  logic [7:0]      ir_q;
  logic [SELW-1:0] x_q, p_q;
  logic [7:0]      t_q;
  logic            ie_q, skip_q;
  dec_t            dec;
  logic [SELW-1:0] addr_sel;
  logic [AW-1:0]   ptr;
  logic            inc_en, exec_done, ie_nx, take_int;

  nib_decode dec_i (.op(ir_q), .d(dec));

  nib_regfile #(.AW(AW)) rf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (addr_sel),
    .inc_en (inc_en),
    .val    (ptr)
  );

  wire in_exec  = (state_q == ST_EXEC);
  wire in_fetch = (state_q == ST_FETCH);

  assign addr_sel  = in_fetch ? p_q : x_q;
  assign exec_done = !(dec.outp && !out_ready);
  assign inc_en    = in_fetch ||
                     (in_exec && (dec.ret || dec.dis || (dec.outp && out_ready)));
  assign ie_nx     = dec.ret ? 1'b1 : (dec.dis ? 1'b0 : ie_q);
  assign take_int  = ie_nx && irq && !skip_q;

  assign mem_addr  = ptr;
  assign mem_rd    = in_fetch || (in_exec && (dec.ret || dec.dis || dec.outp));
  assign mem_wr    = in_exec && dec.sav;
  assign mem_wdata = t_q;
  assign out_valid = in_exec && dec.outp;
  assign out_port  = ir_q[2:0];
  assign out_data  = mem_rdata;
  assign x         = x_q;
  assign p         = p_q;
  assign t         = t_q;
  assign ie        = ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
      x_q     <= '0;
      p_q     <= '0;
      t_q     <= '0;
      ie_q    <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_FETCH: begin
          ir_q    <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (dec.sel_x) x_q <= dec.arg;
          if (dec.ret || dec.dis) begin
            x_q <= mem_rdata[7:4];
            p_q <= mem_rdata[3:0];
          end
          ie_q <= ie_nx;
          if (exec_done) begin
            skip_q  <= 1'b0;
            state_q <= take_int ? ST_INTR : ST_FETCH;
          end
        end
        ST_INTR: begin
          t_q     <= {x_q, p_q};
          x_q     <= INT_X;
          p_q     <= INT_P;
          ie_q    <= 1'b0;
          skip_q  <= 1'b1;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/nib_irq_chk.sv
module nib_irq_chk
  import nib_pkg::*;
#(
  parameter logic [SELW-1:0] INT_P = 4'd1,
  parameter logic [SELW-1:0] INT_X = 4'd2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input seq_t       state,
  input logic [7:0] ir,
  input logic [3:0] x,
  input logic [3:0] p,
  input logic [7:0] t,
  input logic       ie,
  input logic       skip,
  input logic       out_valid,
  input logic       out_ready,
  input logic [2:0] out_port,
  input logic [7:0] out_data,
  input logic       mem_rd,
  input logic       mem_wr
);
  AST_INT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTR) |=> (x == INT_X && p == INT_P && !ie && t == {$past(x), $past(p)})); // R2

  AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTR) |-> ie); // R3

  AST_INT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTR) |-> ($past(irq) && !$past(skip))); // R10

  AST_RET_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ir == 8'h70) |=> ie); // R4

  AST_DIS_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ir == 8'h71) |=> (!ie && state != ST_INTR)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_data))); // R12

  AST_INTR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTR) |-> (!mem_rd && !mem_wr)); // R13

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr}) <= 1); // R13
endmodule

bind nib_irq_ctrl nib_irq_chk #(.INT_P(INT_P), .INT_X(INT_X)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .state     (state_q),
  .ir        (ir_q),
  .x         (x_q),
  .p         (p_q),
  .t         (t_q),
  .ie        (ie_q),
  .skip      (skip_q),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_port  (out_port),
  .out_data  (out_data),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/nib_irq_ctrl_tb_top.sv
module nib_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        out_ready = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, out_valid, ie;
  logic [7:0]  mem_wdata, mem_rdata, out_data, t;
  logic [2:0]  out_port;
  logic [3:0]  x, p;
  logic [7:0]  mem [256];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  nib_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_data(out_data),
    .x(x), .p(p), .t(t), .ie(ie)
  );

  function automatic logic [7:0] pack_t(input logic [3:0] xs, input logic [3:0] ps);
    return {xs, ps};
  endfunction

  function automatic bit is_out(input logic [7:0] op);
    return (op[7:4] == 4'h6) && !op[3] && (op[2:0] != 3'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  // Random program with a bench reference model
  task automatic run_random(input int n_ins);
    logic [15:0] rf [16];
    logic [3:0]  mx, mp, gx;
    logic        mie;
    int          a, k;
    logic [7:0]  op, d;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    a = 0; gx = 4'd0;
    for (int i = 0; i < n_ins; i++) begin
      k = int'($urandom % 4);
      if (k == 0) begin
        op = {4'hE, 4'($urandom)}; mem[a] = op; a++; gx = op[3:0];
      end else if (k == 1 && gx == 4'd0) begin
        mem[a] = ($urandom % 2 == 0) ? 8'h70 : 8'h71;
        gx = 4'($urandom);
        mem[a+1] = {gx, 4'd0}; a += 2;
      end else begin
        mem[a] = {5'b01100, 3'(1 + $urandom % 7)};
        if (gx == 4'd0) begin mem[a+1] = 8'($urandom); a += 2; end
        else a++;
      end
    end
    for (int i = 0; i < 16; i++) rf[i] = 16'd0;
    mx = 4'd0; mp = 4'd0; mie = 1'b0;
    irq = 1'b0; out_ready = 1'b1;
    do_reset();
    for (int i = 0; i < n_ins; i++) begin
      chk(mem_rd && mem_addr == rf[mp], "R6", "fetch address", mem_addr, rf[mp]);
      chk(x == mx && p == mp, "R8", "selectors {x,p}", {8'd0, x, p}, {8'd0, mx, mp});
      chk(ie == mie, "R4", "ie", 16'(ie), 16'(mie));
      op = mem[rf[mp][7:0]];
      rf[mp] = rf[mp] + 16'd1;
      cyc();
      if (op[7:4] == 4'hE) mx = op[3:0];
      else if (op == 8'h70 || op == 8'h71) begin
        d = mem[rf[mx][7:0]];
        rf[mx] = rf[mx] + 16'd1;
        mie = (op == 8'h70);
        mx = d[7:4]; mp = d[3:0];
      end else if (is_out(op)) begin
        k = int'($urandom % 3);
        out_ready = (k == 0);
        for (int s = 0; s < k; s++) begin
          cyc();
          chk(out_valid && out_port == op[2:0] && mem_addr == rf[mx],
              "R12", "stalled output hold", {5'd0, out_port, out_data}, {5'd0, op[2:0], mem[rf[mx][7:0]]});
        end
        out_ready = 1'b1;
        #1;
        chk(out_valid && out_port == op[2:0] && out_data == mem[rf[mx][7:0]],
            "R7", "output port/data", {5'd0, out_port, out_data}, {5'd0, op[2:0], mem[rf[mx][7:0]]});
        rf[mx] = rf[mx] + 16'd1;
      end
      cyc();
    end
  endtask

  initial begin
    @(negedge clk);
    // Directed: reset state, return/disable inline operands, output, save
    clear_mem();
    mem[0] = 8'hE0; mem[1] = 8'h70; mem[2] = 8'h00; mem[3] = 8'h71; mem[4] = 8'h00;
    mem[5] = 8'h61; mem[6] = 8'h5A; mem[7] = 8'h67; mem[8] = 8'hC3;
    mem[9] = 8'h63; mem[10] = 8'h11; mem[11] = 8'hE4; mem[12] = 8'h78;
    mem[13] = 8'hE0;
    do_reset();
    chk(x == 0 && p == 0 && t == 0 && !ie, "R1", "reset x/p/t/ie", {4'd0, x, t}, 16'd0);
    chk(mem_rd && mem_addr == 0 && !out_valid, "R1", "first fetch", mem_addr, 16'd0);
    cyc(); cyc();
    chk(mem_addr == 1 && x == 0, "R8", "after select-x", mem_addr, 16'd1);
    cyc(); cyc();
    chk(mem_addr == 3 && ie && x == 0 && p == 0, "R4", "return with x==p", mem_addr, 16'd3);
    cyc(); cyc();
    chk(mem_addr == 5 && !ie, "R5", "disable with x==p", {mem_addr[14:0], ie}, {15'd5, 1'b0});
    irq = 1'b1;
    cyc();
    chk(out_valid && out_port == 3'd1 && out_data == 8'h5A && mem_addr == 6, "R6",
        "inline output operand", {5'd0, out_port, out_data}, {5'd0, 3'd1, 8'h5A});
    cyc();
    chk(mem_rd && mem_addr == 7, "R3", "irq ignored while ie=0", mem_addr, 16'd7);
    cyc();
    chk(out_valid && out_port == 3'd7 && out_data == 8'hC3, "R7", "port 7",
        {5'd0, out_port, out_data}, {5'd0, 3'd7, 8'hC3});
    cyc(); cyc();
    out_ready = 1'b0;
    cyc(); cyc();
    chk(out_valid && out_port == 3'd3 && out_data == 8'h11 && mem_addr == 10, "R12",
        "held under back-pressure", {5'd0, out_port, out_data}, {5'd0, 3'd3, 8'h11});
    out_ready = 1'b1;
    cyc();
    chk(mem_rd && mem_addr == 11, "R13", "fetch after stall", mem_addr, 16'd11);
    cyc(); cyc();
    chk(x == 4'd4, "R8", "select register 4", 16'(x), 16'd4);
    cyc();
    chk(mem_wr && !mem_rd && mem_addr == 0 && mem_wdata == pack_t(4'd0, 4'd0), "R9",
        "save writes t", {mem_addr[7:0], mem_wdata}, 16'h0000);
    cyc();
    chk(mem_rd && mem_addr == 13, "R9", "save leaves pointer", mem_addr, 16'd13);
    irq = 1'b0;

    // Directed: interrupt entry, save, return, re-entry, first-instruction guard
    clear_mem();
    mem[0] = 8'hE0; mem[1] = 8'h70; mem[2] = 8'h34; mem[3] = 8'hE5;
    irq = 1'b1;
    do_reset();
    cyc(); cyc();
    chk(mem_rd && mem_addr == 1, "R3", "no response with ie=0", mem_addr, 16'd1);
    cyc(); cyc();
    chk(!mem_rd && !mem_wr && x == 4'd3 && p == 4'd4 && ie, "R13", "response cycle idle",
        {14'd0, mem_rd, mem_wr}, 16'd0);
    mem[0] = 8'h78;
    cyc();
    chk(t == pack_t(4'd3, 4'd4) && x == 4'd2 && p == 4'd1 && !ie && mem_rd && mem_addr == 0,
        "R2", "entry state", {t, x, p}, {pack_t(4'd3, 4'd4), 4'd2, 4'd1});
    mem[2] = 8'h70;
    cyc();
    chk(mem_wr && mem_addr == 0 && mem_wdata == 8'h34, "R9", "save of parked byte",
        {mem_addr[7:0], mem_wdata}, 16'h0034);
    cyc(); cyc(); cyc();
    chk(!mem_rd && x == 4'd3 && p == 4'd4 && ie, "R11", "re-entry after return",
        {11'd0, mem_rd, x}, {11'd0, 1'b0, 4'd3});
    cyc();
    chk(mem_rd && mem_addr == 2 && t == 8'h34, "R2", "second entry", {mem_addr[7:0], t}, 16'h0234);
    cyc(); cyc();
    chk(mem_rd && mem_addr == 3 && x == 4'd7 && p == 4'd0 && ie, "R10", "guarded first instruction",
        mem_addr, 16'd3);
    cyc(); cyc();
    chk(!mem_rd && !mem_wr, "R11", "response after guard", {15'd0, mem_rd}, 16'd0);
    cyc();
    chk(t == pack_t(4'd5, 4'd0) && x == 4'd2 && p == 4'd1, "R2", "third entry", {8'd0, t}, 16'h0050);
    irq = 1'b0;

    // Constrained random programs
    void'($urandom(32'd1802));
    for (int r = 0; r < 4; r++) run_random(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule